// File: doc/BRIEF.md
# Hardware Monitor Limit and Alarm Unit

This block sits behind the analog converters of a board-level health monitor. It keeps one sample register and a set of programmable limits for each channel it watches: five voltage channels, two fan-speed channels and one temperature channel. An internal timer produces a slow refresh tick. On each tick the per-channel parallel inputs are captured into the sample registers. In the same cycle each fresh value is compared against its limits. Any violation sets a sticky bit in a single status word.

A host reaches the limits, samples and status through a simple register port with read strobe, write strobe, address and data. Read data comes back one cycle after the request, flagged by a valid pulse. Reading the status word clears it, but an alarm raised in that same cycle survives the clear. One input pin is shared between the fifth voltage channel and the temperature channel, and a strap input decides which of the two it feeds. An external over-temperature input is folded into the status word as its own bit.

Top module: `hwm_limit_unit`

## Requirements
- R1: The refresh tick `update_o` is high for one cycle out of every `REFRESH_CYCLES` cycles, first in cycle `REFRESH_CYCLES-1` after reset. Sample registers change only on the edge that ends a tick cycle. Reads in between return the previous values.
- R2: Voltage codes are 8-bit unsigned, at 16 mV per step, so that 255 means 4.08 V. A voltage alarm bit sets on a tick when the new code is strictly above its maximum or strictly below its minimum.
- R3: A fan alarm bit sets on a tick when the new speed code is strictly below that fan's limit. A high speed never raises it.
- R4: Temperature codes are signed two's complement, one degree Celsius per step, valid from -55 to +125. The temperature alarm sets on a tick when the code is strictly above the maximum or strictly below the minimum, both compared as signed values.
- R5: The external alarm bit sets at any clock edge where `ext_alarm_i` is high.
- R6: Status word layout: bits 0 to 4 are voltage channels 0 to 4, bits 5 and 6 are fans 0 and 1, bit 7 is temperature, bit 8 is external, and the upper bits read zero.
- R7: A set status bit stays set, even after its cause has gone, until the status word is read. The read returns the current content and then clears it.
- R8: When a bit's set condition arrives on the same edge as a clearing status read, the bit is set after that edge. The read returns the content from before that edge.
- R9: With `temp_mode_i` = 1, the shared input feeds the temperature channel. Voltage channel 4 then keeps its sample and never raises its alarm. With `temp_mode_i` = 0, the shared input feeds voltage channel 4, and the temperature sample holds and its alarm never rises.
- R10: After reset all samples are 0 and the status word is 0. Voltage maxima reset to 255 and voltage minima to 0. Fan limits reset to 0. Temperature maximum resets to +127 (0x7F) and minimum to -128 (0x80). As a result, no alarm fires before the host programs the limits.
- R11: Word addresses: voltage samples at 0x00+n, voltage maxima at 0x08+n, voltage minima at 0x10+n, fan samples at 0x18+k, fan limits at 0x1A+k, temperature sample at 0x1C, its maximum at 0x1D, its minimum at 0x1E, and status at 0x20. A read request returns zero-extended data on `reg_rdata_o`, with `reg_rvalid_o` high in the cycle after the request. A write to a limit address takes effect on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| volt_i | input | (N_VOLT-1)*SW | Dedicated voltage channel codes, channel n at bits n*SW |
| fan_i | input | N_FAN*SW | Fan speed codes, fan k at bits k*SW |
| shared_i | input | SW | Shared input: last voltage channel or temperature |
| temp_mode_i | input | 1 | Strap: 1 routes the shared input to temperature |
| ext_alarm_i | input | 1 | External over-limit indication |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | AW | Register word address |
| reg_wdata_i | input | SW | Write data |
| reg_rdata_o | output | DW | Read data |
| reg_rvalid_o | output | 1 | Read data valid, one cycle after the request |
| update_o | output | 1 | Refresh tick |

## Verification
The embedded properties watch, on every cycle, that the sample registers stay still outside a tick and that the refresh tick never lasts two cycles. They also check that no status bit drops without a status read, that a clearing read empties the word when nothing new arrives, that a set arriving with a clear survives it, and that the channel deselected by the strap never gains an alarm. Other behaviour can only be shown by the bench scenarios, which compare read values against expected values: the comparison direction for each channel type, signed handling of temperature codes, the exact tick period, the reset values of the limits, the address map, and the stale values returned between refreshes.

// File: rtl/hwm_pkg.sv
package hwm_pkg;
   // word addresses of the register port
   localparam int unsigned ADR_VIN  = 'h00;
   localparam int unsigned ADR_VMAX = 'h08;
   localparam int unsigned ADR_VMIN = 'h10;
   localparam int unsigned ADR_FIN  = 'h18;
   localparam int unsigned ADR_FLIM = 'h1A;
   localparam int unsigned ADR_TIN  = 'h1C;
   localparam int unsigned ADR_TMAX = 'h1D;
   localparam int unsigned ADR_TMIN = 'h1E;
   localparam int unsigned ADR_STAT = 'h20;
   // room reserved per block in the map
   localparam int unsigned MAX_VOLT = 8;
   localparam int unsigned MAX_FAN  = 2;
endpackage

// File: rtl/hwm_tick.sv
module hwm_tick #(
   parameter int unsigned PERIOD = 150_000_000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
   localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

   logic [CW-1:0] cnt_q;

   if (PERIOD < 2) begin : g_bad_period
      $error("hwm_tick: PERIOD must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (tick_o) cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
   end

   assign tick_o = (cnt_q == LAST);

   AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o); // R1
endmodule

// File: rtl/hwm_window.sv
module hwm_window #(
   parameter int unsigned W      = 8,
   parameter bit          SIGNED = 1'b0
) (
   input  logic [W-1:0] smp_i,
   input  logic [W-1:0] lo_i,
   input  logic [W-1:0] hi_i,
   output logic         out_o
);
   logic above, below;

   if (SIGNED) begin : g_signed
      assign above = $signed(smp_i) > $signed(hi_i);
      assign below = $signed(smp_i) < $signed(lo_i);
   end else begin : g_unsigned
      assign above = smp_i > hi_i;
      assign below = smp_i < lo_i;
   end

   assign out_o = above | below;
endmodule

// File: rtl/hwm_sticky.sv
module hwm_sticky #(
   parameter int unsigned N = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic         clr_i,
   output logic [N-1:0] stat_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) stat_o <= '0;
      else        stat_o <= (clr_i ? '0 : stat_o) | set_i;
   end

   AST_NO_SILENT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> ((stat_o & $past(stat_o)) == $past(stat_o))); // R7
   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && set_i == '0) |=> (stat_o == '0)); // R7
   AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i != '0) |=> ((stat_o & $past(set_i)) == $past(set_i))); // R8
endmodule

// File: rtl/hwm_limit_unit.sv
module hwm_limit_unit
   import hwm_pkg::*;
#(
   parameter int unsigned N_VOLT         = 5,
   parameter int unsigned N_FAN          = 2,
   parameter int unsigned SW             = 8,
   parameter int unsigned DW             = 16,
   parameter int unsigned AW             = 6,
   parameter int unsigned REFRESH_CYCLES = 150_000_000
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [(N_VOLT-1)*SW-1:0]  volt_i,
   input  logic [N_FAN*SW-1:0]       fan_i,
   input  logic [SW-1:0]             shared_i,
   input  logic                      temp_mode_i,
   input  logic                      ext_alarm_i,
   input  logic                      reg_wr_i,
   input  logic                      reg_rd_i,
   input  logic [AW-1:0]             reg_addr_i,
   input  logic [SW-1:0]             reg_wdata_i,
   output logic [DW-1:0]             reg_rdata_o,
   output logic                      reg_rvalid_o,
   output logic                      update_o
);
   localparam int unsigned NS     = N_VOLT + N_FAN + 2;
   localparam int unsigned B_FAN  = N_VOLT;
   localparam int unsigned B_TEMP = N_VOLT + N_FAN;
   localparam int unsigned B_EXT  = N_VOLT + N_FAN + 1;
   localparam int unsigned LASTV  = N_VOLT - 1;
   localparam logic [SW-1:0] FULL   = '1;
   localparam logic [SW-1:0] T_TOP  = {1'b0, {(SW-1){1'b1}}};
   localparam logic [SW-1:0] T_BOT  = {1'b1, {(SW-1){1'b0}}};

   // elaboration checks
   if (N_VOLT < 2 || N_VOLT > MAX_VOLT) begin : g_chk_volt
      $error("hwm_limit_unit: N_VOLT out of range");
   end
   if (N_FAN < 1 || N_FAN > MAX_FAN) begin : g_chk_fan
      $error("hwm_limit_unit: N_FAN out of range");
   end
   if (DW < NS || DW < SW) begin : g_chk_dw
      $error("hwm_limit_unit: DW too narrow for status word");
   end
   if (SW < 2) begin : g_chk_sw
      $error("hwm_limit_unit: SW too small");
   end
   if ((2 ** AW) <= ADR_STAT) begin : g_chk_aw
      $error("hwm_limit_unit: AW too small for register map");
   end

   logic tick;
   logic [SW-1:0] v_raw [N_VOLT];
   logic [SW-1:0] v_smp [N_VOLT];
   logic [SW-1:0] v_max [N_VOLT];
   logic [SW-1:0] v_min [N_VOLT];
   logic [SW-1:0] f_raw [N_FAN];
   logic [SW-1:0] f_smp [N_FAN];
   logic [SW-1:0] f_lim [N_FAN];
   logic [SW-1:0] t_smp, t_max, t_min;
   logic [NS-1:0] set_vec, stat;
   logic          stat_clr;
   logic [DW-1:0] rd_mux;

   hwm_tick #(.PERIOD(REFRESH_CYCLES)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick)
   );
   assign update_o = tick;

   // ---------------- voltage channels ----------------
   for (genvar i = 0; i < N_VOLT; i++) begin : g_volt
      logic hit;
      logic live;
      if (i < N_VOLT - 1) begin : g_ded
         assign v_raw[i] = volt_i[i*SW +: SW];
         assign live     = 1'b1;
      end else begin : g_shr
         assign v_raw[i] = shared_i;
         assign live     = !temp_mode_i;
      end

      hwm_window #(.W(SW), .SIGNED(1'b0)) u_win (
         .smp_i (v_raw[i]),
         .lo_i  (v_min[i]),
         .hi_i  (v_max[i]),
         .out_o (hit)
      );
      assign set_vec[i] = tick & live & hit;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_smp[i] <= '0;
            v_max[i] <= FULL;
            v_min[i] <= '0;
         end else begin
            if (tick && live) v_smp[i] <= v_raw[i];
            if (reg_wr_i && reg_addr_i == AW'(ADR_VMAX + i)) v_max[i] <= reg_wdata_i;
            if (reg_wr_i && reg_addr_i == AW'(ADR_VMIN + i)) v_min[i] <= reg_wdata_i;
         end
      end

      AST_VSMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !tick |=> $stable(v_smp[i])); // R1
   end

   // ---------------- fan channels ----------------
   for (genvar k = 0; k < N_FAN; k++) begin : g_fan
      logic hit;
      assign f_raw[k] = fan_i[k*SW +: SW];

      // upper bound at full scale: only the low side can trip
      hwm_window #(.W(SW), .SIGNED(1'b0)) u_win (
         .smp_i (f_raw[k]),
         .lo_i  (f_lim[k]),
         .hi_i  (FULL),
         .out_o (hit)
      );
      assign set_vec[B_FAN + k] = tick & hit;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            f_smp[k] <= '0;
            f_lim[k] <= '0;
         end else begin
            if (tick) f_smp[k] <= f_raw[k];
            if (reg_wr_i && reg_addr_i == AW'(ADR_FLIM + k)) f_lim[k] <= reg_wdata_i;
         end
      end

      AST_FSMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !tick |=> $stable(f_smp[k])); // R1
   end

   // ---------------- temperature channel ----------------
   logic t_hit;
   hwm_window #(.W(SW), .SIGNED(1'b1)) u_twin (
      .smp_i (shared_i),
      .lo_i  (t_min),
      .hi_i  (t_max),
      .out_o (t_hit)
   );
   assign set_vec[B_TEMP] = tick & temp_mode_i & t_hit;
   assign set_vec[B_EXT]  = ext_alarm_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         t_smp <= '0;
         t_max <= T_TOP;
         t_min <= T_BOT;
      end else begin
         if (tick && temp_mode_i) t_smp <= shared_i;
         if (reg_wr_i && reg_addr_i == AW'(ADR_TMAX)) t_max <= reg_wdata_i;
         if (reg_wr_i && reg_addr_i == AW'(ADR_TMIN)) t_min <= reg_wdata_i;
      end
   end

   // ---------------- status word ----------------
   assign stat_clr = reg_rd_i && (reg_addr_i == AW'(ADR_STAT));

   hwm_sticky #(.N(NS)) u_stat (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_vec),
      .clr_i  (stat_clr),
      .stat_o (stat)
   );

   // ---------------- read path ----------------
   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < N_VOLT; i++) begin
         if (reg_addr_i == AW'(ADR_VIN  + i)) rd_mux = DW'(v_smp[i]);
         if (reg_addr_i == AW'(ADR_VMAX + i)) rd_mux = DW'(v_max[i]);
         if (reg_addr_i == AW'(ADR_VMIN + i)) rd_mux = DW'(v_min[i]);
      end
      for (int k = 0; k < N_FAN; k++) begin
         if (reg_addr_i == AW'(ADR_FIN  + k)) rd_mux = DW'(f_smp[k]);
         if (reg_addr_i == AW'(ADR_FLIM + k)) rd_mux = DW'(f_lim[k]);
      end
      if (reg_addr_i == AW'(ADR_TIN))  rd_mux = DW'(t_smp);
      if (reg_addr_i == AW'(ADR_TMAX)) rd_mux = DW'(t_max);
      if (reg_addr_i == AW'(ADR_TMIN)) rd_mux = DW'(t_min);
      if (reg_addr_i == AW'(ADR_STAT)) rd_mux = DW'(stat);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_rdata_o  <= '0;
         reg_rvalid_o <= 1'b0;
      end else begin
         reg_rvalid_o <= reg_rd_i;
         if (reg_rd_i) reg_rdata_o <= rd_mux;
      end
   end

   AST_TSMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(tick && temp_mode_i) |=> $stable(t_smp)); // R9
   AST_V_LAST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (temp_mode_i && !stat[LASTV]) |=> !stat[LASTV]); // R9
   AST_TEMP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!temp_mode_i && !stat[B_TEMP]) |=> !stat[B_TEMP]); // R9
   AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_i |=> reg_rvalid_o); // R11
endmodule

// File: tb/hwm_limit_unit_tb_top.sv
`timescale 1ns/1ps
module hwm_limit_unit_tb_top;
   localparam int unsigned NV = 5;
   localparam int unsigned NF = 2;
   localparam int unsigned P  = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [(NV-1)*8-1:0] volt_i = '0;
   logic [NF*8-1:0]     fan_i = '0;
   logic [7:0]          shared_i = '0;
   logic temp_mode_i = 1'b0, ext_alarm_i = 1'b0;
   logic reg_wr_i = 1'b0, reg_rd_i = 1'b0;
   logic [5:0] reg_addr_i = '0;
   logic [7:0] reg_wdata_i = '0;
   logic [15:0] reg_rdata_o;
   logic reg_rvalid_o, update_o;

   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;
   logic [15:0] exp_q[$];
   string       tag_q[$];

   always #5 clk = ~clk;

   hwm_limit_unit #(.N_VOLT(NV), .N_FAN(NF), .REFRESH_CYCLES(P)) dut_i (
      .clk(clk), .rst_n(rst_n), .volt_i(volt_i), .fan_i(fan_i),
      .shared_i(shared_i), .temp_mode_i(temp_mode_i), .ext_alarm_i(ext_alarm_i),
      .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_addr_i(reg_addr_i),
      .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
      .reg_rvalid_o(reg_rvalid_o), .update_o(update_o));

   function automatic void check(string tag, logic [15:0] act, logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
      end
   endfunction

   // monitor: pops one expected item per returned read
   always @(negedge clk) begin
      if (rst_n && reg_rvalid_o) begin
         if (exp_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R11: unexpected read data 0x%04h, expected none", reg_rdata_o);
         end else begin
            check(tag_q.pop_front(), reg_rdata_o, exp_q.pop_front());
         end
      end
   end

   // driver tasks: entered and left at a falling edge
   task automatic rd(input int adr, input logic [15:0] exp, input string tag);
      reg_rd_i = 1'b1; reg_addr_i = 6'(adr);
      exp_q.push_back(exp); tag_q.push_back(tag);
      @(negedge clk);
      reg_rd_i = 1'b0;
   endtask

   task automatic wr(input int adr, input logic [7:0] d);
      reg_wr_i = 1'b1; reg_addr_i = 6'(adr); reg_wdata_i = d;
      @(negedge clk);
      reg_wr_i = 1'b0;
   endtask

   task automatic to_tick_cycle();
      do @(negedge clk); while (!update_o);
   endtask

   task automatic wait_refresh();
      to_tick_cycle();
      @(negedge clk);
   endtask

   task automatic set_volt(input int n, input logic [7:0] v);
      volt_i[n*8 +: 8] = v;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int gap;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R10 reset values (before first tick at cycle P-1)
      rd('h08, 16'h00FF, "R10 vmax0");
      rd('h13, 16'h0000, "R10 vmin3");
      rd('h1B, 16'h0000, "R10 flim1");
      rd('h1D, 16'h007F, "R10 tmax");
      rd('h1E, 16'h0080, "R10 tmin");
      rd('h00, 16'h0000, "R10 vin0");
      rd('h20, 16'h0000, "R10 status");

      // R1 tick period
      to_tick_cycle();
      gap = 0;
      do begin @(negedge clk); gap++; end while (!update_o);
      check("R1 tick period", 16'(gap), 16'(P));

      // program limits (R11)
      for (int i = 0; i < 4; i++) set_volt(i, 8'd100);
      shared_i = 8'd100; fan_i = {8'd150, 8'd255};
      for (int i = 0; i < NV; i++) begin
         wr('h08 + i, 8'd200); wr('h10 + i, 8'd50);
      end
      wr('h1A, 8'd100); wr('h1B, 8'd100);
      wr('h1D, 8'd40);  wr('h1E, 8'hF6);
      rd('h0A, 16'd200, "R11 vmax2 write");
      rd('h1E, 16'h00F6, "R11 tmin write");
      wait_refresh();
      rd('h20, 16'h0000, "R3 fast fan no alarm");
      wait_refresh();
      rd('h00, 16'd100, "R1 vin0");
      rd('h19, 16'd150, "R11 fin1");
      rd('h20, 16'h0000, "R2 in range");

      // R2/R3/R6 violations then cause removed (R7 sticky)
      set_volt(0, 8'd201); set_volt(1, 8'd49);
      fan_i[15:8] = 8'd99; shared_i = 8'd201;
      wait_refresh();
      set_volt(0, 8'd200); set_volt(1, 8'd50);
      fan_i[15:8] = 8'd100; shared_i = 8'd100;
      wait_refresh();
      rd('h20, 16'h0053, "R7 sticky R6 layout R2 R3");
      rd('h20, 16'h0000, "R7 cleared by read");
      rd('h20, 16'h0000, "R2 boundary equal no alarm");

      // R1 stale between refreshes
      set_volt(2, 8'd77);
      rd('h02, 16'd100, "R1 stale vin2");
      wait_refresh();
      rd('h02, 16'd77, "R1 refreshed vin2");

      // R9 / R4 temperature mode
      temp_mode_i = 1'b1; shared_i = 8'hD0;
      wait_refresh();
      rd('h20, 16'h0080, "R4 below min R9 no v4");
      rd('h1C, 16'h00D0, "R9 temp sample");
      rd('h04, 16'd100, "R9 v4 held");
      shared_i = 8'h1E;
      wait_refresh();
      rd('h20, 16'h0000, "R4 signed in range");
      shared_i = 8'h29;
      wait_refresh();
      rd('h20, 16'h0080, "R4 above max");
      temp_mode_i = 1'b0; shared_i = 8'd100;
      wait_refresh();
      rd('h20, 16'h0000, "R9 temp quiet in volt mode");
      rd('h1C, 16'h0029, "R9 temp sample held");
      rd('h04, 16'd100, "R9 v4 live again");

      // R5 external alarm
      ext_alarm_i = 1'b1; @(negedge clk); ext_alarm_i = 1'b0;
      rd('h20, 16'h0100, "R5 ext bit");
      rd('h20, 16'h0000, "R5 ext cleared R7");

      // R8 set wins against a clearing read in the tick cycle
      set_volt(3, 8'd250);
      wait_refresh();
      rd('h20, 16'h0008, "R8 first set");
      to_tick_cycle();
      rd('h20, 16'h0000, "R8 read returns pre-edge");
      rd('h20, 16'h0008, "R8 set survived clear");
      set_volt(3, 8'd100);

      repeat (4) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_cmp++; n_bad++;
         $display("FAIL R11: actual %0d reads pending expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule